// File: doc/BRIEF.md
# SD/MMC Host Command Front End

This block is the register-side command engine of an SD/MMC host controller. Software loads a 32-bit command argument in two 16-bit halves, enables the controller and then writes a 16-bit command word. The block decodes that word and, unless it is the initialization pseudo-command, sends a single-cycle request carrying the command index, the argument and the transfer attributes to a card-side agent. It then waits for that agent's done strobe.

When the done strobe arrives, the block receives the whole response as a byte array with a byte count. It checks the count against what the response type needs and flags a timeout when the reply is too short. It tests the card status carried in short responses against an error mask chosen by the response type. It stores a valid response in eight 16-bit response words and raises completion bits in a sticky status register. Software clears status bits by writing ones. A single interrupt line is raised while any status bit is set whose enable bit is set in a mask register.

Serial timing, CRC generation and checking, and card state tracking are left to the card-side agent.

Top module: `sdcmd_front`

## Requirements
- R1: After reset the status word, the response words, the argument, the interrupt, `busy_o` and `card_req_o` are all zero.
- R2: A write to address 1 replaces argument bits 15:0, and a write to address 2 replaces argument bits 31:16. Each write keeps the other half. The argument is visible on `card_arg_o`.
- R3: A command write (address 0) has no effect while the enable bit (bit 0 of a write to address 3) is clear or while a command is pending. In that case no request is sent and the status and response words stay unchanged.
- R4: The command word carries the index in bits 5:0, the init flag in bit 7, the response type in bits 10:8, the busy flag in bit 11, the transfer kind in bits 13:12 and the direction in bit 15. An accepted command clears all eight response words. It pulses `card_req_o` for exactly one cycle, the cycle after the write, and holds `busy_o` until `card_done_i`. During that time `card_index_o`, `card_kind_o` and `card_dir_o` show the fields. `card_wait_o` is 1 only for response type 1 with the busy flag set.
- R5: A command write with the init flag set and index 0 sends no request, leaves `busy_o` low, and sets status bit 0 in the cycle after the write.
- R6: Response types 1, 3 and 6 need a byte count of at least 4, and type 2 needs at least 16. A shorter reply sets status bit 7 (timeout) and not bit 0. Type 0 and types 4, 5 and 7 never time out.
- R7: For type 1, with or without the busy flag, the status word is {byte0, byte1, byte2, byte3}. If it ANDed with 0xFDF90000 is nonzero, status bit 14 is set. For type 6, {byte2, byte3} is tested against 0xE008 in the same way. Types 2 and 3 never set bit 14.
- R8: On a non-timeout reply of type 1, 2, 3 or 6, response word i holds {byte[2k], byte[2k+1]} with k = 7 - i, the even byte in the upper half. For other types, and on a timeout, the words stay zero.
- R9: A non-timeout reply sets status bit 0. If the command index is 12, it sets bits 0 and 2.
- R10: A write to address 4 clears every status bit written as 1. A bit set by a reply in the same cycle stays set.
- R11: A write to address 5 loads the interrupt mask from bits 14:0. `irq_o` is 1 exactly while status AND mask is nonzero.
- R12: `card_done_i` is ignored while no command is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 command, 1 arg low, 2 arg high, 3 control, 4 status clear, 5 mask |
| wr_data | input | 16 | Register write data |
| card_req_o | output | 1 | One-cycle command request to the card agent |
| card_index_o | output | 6 | Command index of the pending command |
| card_arg_o | output | 32 | Current command argument |
| card_kind_o | output | 2 | Transfer kind field of the pending command |
| card_dir_o | output | 1 | Direction field of the pending command |
| card_wait_o | output | 1 | Reply carries busy signalling |
| card_done_i | input | 1 | Reply available strobe |
| card_len_i | input | 5 | Number of valid reply bytes |
| card_bytes_i | input | 128 | Reply bytes, byte j in bits 8j+7:8j |
| rsp_sel_i | input | 3 | Response word select |
| rsp_word_o | output | 16 | Selected response word |
| status_o | output | 16 | Status word |
| irq_o | output | 1 | Interrupt request |
| busy_o | output | 1 | A command is waiting for its reply |

## Verification
The bench builds the block with its default eight-word response bank, so the reply bus is 16 bytes wide and the byte count is 5 bits. This puts the long-response boundary between counts 15 and 16 within reach, and also the short-response boundary between 3 and 4. The full byte-pair ordering is checked across all eight words. Card status patterns are chosen to hit single bits inside and just outside each error mask. The stop index, the init pseudo-command and a reply arriving in the same cycle as a status clear are all driven.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    // register select codes
    localparam logic [2:0] ADR_CMD   = 3'd0;
    localparam logic [2:0] ADR_ARGLO = 3'd1;
    localparam logic [2:0] ADR_ARGHI = 3'd2;
    localparam logic [2:0] ADR_CTRL  = 3'd3;
    localparam logic [2:0] ADR_STAT  = 3'd4;
    localparam logic [2:0] ADR_MASK  = 3'd5;

    // status word geometry
    localparam int STAT_W  = 16;
    localparam int ST_DONE = 0;
    localparam int ST_STOP = 2;
    localparam int ST_TMO  = 7;
    localparam int ST_RERR = 14;

    // response type codes
    localparam logic [2:0] RT_NONE  = 3'd0;
    localparam logic [2:0] RT_SHORT = 3'd1;
    localparam logic [2:0] RT_LONG  = 3'd2;
    localparam logic [2:0] RT_COND  = 3'd3;
    localparam logic [2:0] RT_ADDR  = 3'd6;

    localparam logic [5:0]  STOP_INDEX     = 6'd12;
    localparam int          SHORT_BYTES    = 4;
    localparam logic [31:0] SHORT_ERR_BITS = 32'hFDF9_0000;
    localparam logic [31:0] ADDR_ERR_BITS  = 32'h0000_E008;

    typedef struct packed {
        logic       dir;
        logic [1:0] kind;
        logic       hold;
        logic [2:0] rtype;
        logic       init;
        logic [5:0] idx;
    } cmd_t;

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic [15:0] word_i,
    output cmd_t        cmd_o,
    output logic        pseudo_o
);
    logic unused_bits;

    always_comb begin
        cmd_o.idx   = word_i[5:0];
        cmd_o.init  = word_i[7];
        cmd_o.rtype = word_i[10:8];
        cmd_o.hold  = word_i[11];
        cmd_o.kind  = word_i[13:12];
        cmd_o.dir   = word_i[15];
        pseudo_o    = word_i[7] && (word_i[5:0] == 6'd0);
    end

    assign unused_bits = word_i[6] ^ word_i[14];

endmodule

// File: rtl/sdcmd_classify.sv
module sdcmd_classify
    import sdcmd_pkg::*;
#(
    parameter int NBYTES = 16,
    parameter int LEN_W  = $clog2(NBYTES + 1)
) (
    input  logic [2:0]        rtype_i,
    input  logic [5:0]        idx_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [31:0]       head_i,
    output logic [STAT_W-1:0] set_o,
    output logic              store_o
);
    logic [31:0] card_stat;
    logic        too_short;
    logic        bad;
    logic        keeps;

    // head_i holds reply bytes 0..3, byte 0 in the low lane
    assign card_stat = {head_i[7:0], head_i[15:8], head_i[23:16], head_i[31:24]};

    always_comb begin
        too_short = 1'b0;
        bad       = 1'b0;
        keeps     = 1'b0;
        unique case (rtype_i)
            RT_SHORT: begin
                too_short = len_i < LEN_W'(SHORT_BYTES);
                bad       = (card_stat & SHORT_ERR_BITS) != 32'd0;
                keeps     = 1'b1;
            end
            RT_LONG: begin
                too_short = len_i < LEN_W'(NBYTES);
                keeps     = 1'b1;
            end
            RT_COND: begin
                too_short = len_i < LEN_W'(SHORT_BYTES);
                keeps     = 1'b1;
            end
            RT_ADDR: begin
                too_short = len_i < LEN_W'(SHORT_BYTES);
                bad       = ({16'd0, card_stat[15:0]} & ADDR_ERR_BITS) != 32'd0;
                keeps     = 1'b1;
            end
            default: begin
                too_short = 1'b0;
            end
        endcase

        set_o = '0;
        if (too_short) begin
            set_o[ST_TMO] = 1'b1;
        end else begin
            set_o[ST_DONE] = 1'b1;
            set_o[ST_STOP] = (idx_i == STOP_INDEX);
            set_o[ST_RERR] = bad;
        end
        store_o = keeps && !too_short;
    end

endmodule

// File: rtl/sdcmd_rsp_pack.sv
module sdcmd_rsp_pack #(
    parameter int NUM_RSP = 8,
    parameter int NBYTES  = 2 * NUM_RSP
) (
    input  logic [8*NBYTES-1:0]       bytes_i,
    output logic [NUM_RSP-1:0][15:0]  words_o
);
    for (genvar i = 0; i < NUM_RSP; i++) begin : g_word
        localparam int K = NUM_RSP - 1 - i;
        assign words_o[i] = {bytes_i[8*(2*K) +: 8], bytes_i[8*(2*K+1) +: 8]};
    end

endmodule

// File: rtl/sdcmd_irq.sv
module sdcmd_irq #(
    parameter int W = 16
) (
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] enable_i,
    output logic         irq_o
);
    assign irq_o = |(status_i & enable_i);

endmodule

// File: rtl/sdcmd_front.sv
module sdcmd_front
    import sdcmd_pkg::*;
#(
    parameter int NUM_RSP = 8,
    localparam int NBYTES = 2 * NUM_RSP,
    localparam int LEN_W  = $clog2(NBYTES + 1),
    localparam int SEL_W  = $clog2(NUM_RSP)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [15:0]         wr_data,
    output logic                card_req_o,
    output logic [5:0]          card_index_o,
    output logic [31:0]         card_arg_o,
    output logic [1:0]          card_kind_o,
    output logic                card_dir_o,
    output logic                card_wait_o,
    input  logic                card_done_i,
    input  logic [LEN_W-1:0]    card_len_i,
    input  logic [8*NBYTES-1:0] card_bytes_i,
    input  logic [SEL_W-1:0]    rsp_sel_i,
    output logic [15:0]         rsp_word_o,
    output logic [STAT_W-1:0]   status_o,
    output logic                irq_o,
    output logic                busy_o
);
    typedef struct packed {
        logic [STAT_W-1:0]        status;
        logic [STAT_W-2:0]        mask;
        logic [31:0]              arg;
        logic                     enable;
        logic                     busy;
        logic                     req;
        cmd_t                     pend;
        logic [NUM_RSP-1:0][15:0] rsp;
    } state_t;

    state_t state_d, state_q;

    cmd_t                     cmd_now;
    logic                     cmd_pseudo;
    logic [STAT_W-1:0]        reply_set;
    logic                     reply_store;
    logic [NUM_RSP-1:0][15:0] reply_words;

    sdcmd_decode u_decode (
        .word_i   (wr_data),
        .cmd_o    (cmd_now),
        .pseudo_o (cmd_pseudo)
    );

    sdcmd_classify #(.NBYTES(NBYTES), .LEN_W(LEN_W)) u_classify (
        .rtype_i (state_q.pend.rtype),
        .idx_i   (state_q.pend.idx),
        .len_i   (card_len_i),
        .head_i  (card_bytes_i[31:0]),
        .set_o   (reply_set),
        .store_o (reply_store)
    );

    sdcmd_rsp_pack #(.NUM_RSP(NUM_RSP), .NBYTES(NBYTES)) u_pack (
        .bytes_i (card_bytes_i),
        .words_o (reply_words)
    );

    sdcmd_irq #(.W(STAT_W)) u_irq (
        .status_i (state_q.status),
        .enable_i ({1'b0, state_q.mask}),
        .irq_o    (irq_o)
    );

    always_comb begin
        logic [STAT_W-1:0] set_bits;
        logic [STAT_W-1:0] clr_bits;

        state_d     = state_q;
        state_d.req = 1'b0;
        set_bits    = '0;
        clr_bits    = '0;

        if (wr_en) begin
            unique case (wr_addr)
                ADR_CMD: begin
                    if (state_q.enable && !state_q.busy) begin
                        state_d.rsp = '0;
                        if (cmd_pseudo) begin
                            set_bits[ST_DONE] = 1'b1;
                        end else begin
                            state_d.busy = 1'b1;
                            state_d.req  = 1'b1;
                            state_d.pend = cmd_now;
                        end
                    end
                end
                ADR_ARGLO: state_d.arg[15:0]  = wr_data;
                ADR_ARGHI: state_d.arg[31:16] = wr_data;
                ADR_CTRL:  state_d.enable     = wr_data[0];
                ADR_STAT:  clr_bits           = wr_data;
                ADR_MASK:  state_d.mask       = wr_data[STAT_W-2:0];
                default: ;
            endcase
        end

        if (state_q.busy && card_done_i) begin
            state_d.busy = 1'b0;
            set_bits     = set_bits | reply_set;
            if (reply_store) begin
                state_d.rsp = reply_words;
            end
        end

        state_d.status = (state_q.status & ~clr_bits) | set_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign card_req_o   = state_q.req;
    assign card_index_o = state_q.pend.idx;
    assign card_arg_o   = state_q.arg;
    assign card_kind_o  = state_q.pend.kind;
    assign card_dir_o   = state_q.pend.dir;
    assign card_wait_o  = (state_q.pend.rtype == RT_SHORT) && state_q.pend.hold;
    assign rsp_word_o   = state_q.rsp[rsp_sel_i];
    assign status_o     = state_q.status;
    assign busy_o       = state_q.busy;

endmodule

// File: rtl/sdcmd_front_chk.sv
module sdcmd_front_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [2:0]  wr_addr,
    input logic        en,
    input logic        card_req_o,
    input logic        card_done_i,
    input logic        busy_o,
    input logic [15:0] status_o,
    input logic        irq_o
);
    // R4: the request is a single-cycle pulse
    p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        card_req_o |=> !card_req_o);

    // R4: a request is always accompanied by a pending command
    p_req_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        card_req_o |-> busy_o);

    // R3: command writes while disabled send nothing
    p_ignore_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0 && !en) |=> !card_req_o);

    // R12: a reply to a pending command ends the wait
    p_done_ends_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && card_done_i) |=> !busy_o);

    // R10: status moves only on a register write or a reply
    p_status_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(busy_o && card_done_i)) |=> $stable(status_o));

    // R6: a timeout never arrives together with a fresh completion
    p_tmo_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[7]) |-> !$rose(status_o[0]));

    // R9: the stop marker comes with completion
    p_stop_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[2]) |-> status_o[0]);

    // R11: no interrupt without some status bit
    p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_o != 16'd0));

endmodule

bind sdcmd_front sdcmd_front_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .en          (state_q.enable),
    .card_req_o  (card_req_o),
    .card_done_i (card_done_i),
    .busy_o      (busy_o),
    .status_o    (status_o),
    .irq_o       (irq_o)
);

// File: tb/sdcmd_front_test.sv
module sdcmd_front_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [15:0]  wr_data = '0;
    logic         card_req_o;
    logic [5:0]   card_index_o;
    logic [31:0]  card_arg_o;
    logic [1:0]   card_kind_o;
    logic         card_dir_o;
    logic         card_wait_o;
    logic         card_done_i = 1'b0;
    logic [4:0]   card_len_i = '0;
    logic [127:0] card_bytes_i = '0;
    logic [2:0]   rsp_sel_i = '0;
    logic [15:0]  rsp_word_o;
    logic [15:0]  status_o;
    logic         irq_o;
    logic         busy_o;

    always #5 clk = ~clk;

    sdcmd_front uut (.*);

    typedef struct {
        string       tag;
        logic [15:0] st;
        logic        irq;
        logic        bsy;
        logic        req;
        logic        wt;
        logic [31:0] arg;
        logic [5:0]  idx;
        logic [2:0]  sel;
        logic [15:0] word;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;

    // bench model, built from the requirements
    logic [15:0] m_status = '0;
    logic [14:0] m_mask = '0;
    logic [31:0] m_arg = '0;
    logic        m_en = 0, m_busy = 0, m_req = 0, m_wait = 0;
    logic [5:0]  m_idx = '0;
    logic [2:0]  m_rt = '0;
    logic [15:0] m_rsp [8];

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic snap(string tag, logic [2:0] sel);
        item_t it;
        rsp_sel_i = sel;
        it.tag = tag; it.st = m_status; it.irq = |(m_status & {1'b0, m_mask});
        it.bsy = m_busy; it.req = m_req; it.wt = m_wait; it.arg = m_arg;
        it.idx = m_idx; it.sel = sel; it.word = m_rsp[sel];
        exp_q.push_back(it);
        tick();
    endtask

    task automatic snap_all(string tag);
        for (int i = 0; i < 8; i++) snap(tag, 3'(i));
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        case (a)
            3'd1: m_arg[15:0] = d;
            3'd2: m_arg[31:16] = d;
            3'd3: m_en = d[0];
            3'd4: m_status = m_status & ~d;
            3'd5: m_mask = d[14:0];
            default: ;
        endcase
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic issue(logic [15:0] w);
        if (m_en && !m_busy) begin
            for (int i = 0; i < 8; i++) m_rsp[i] = '0;
            if (w[7] && w[5:0] == 6'd0) begin
                m_status[0] = 1'b1;
            end else begin
                m_busy = 1; m_req = 1; m_idx = w[5:0]; m_rt = w[10:8];
                m_wait = (w[10:8] == 3'd1) && w[11];
            end
        end
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = w;
        tick();
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] exp_set(logic [2:0] rt, logic [5:0] idx, int len,
                                            logic [127:0] b, output logic store);
        int need;
        logic [15:0] r;
        logic [31:0] cs;
        need  = (rt == 3'd1 || rt == 3'd3 || rt == 3'd6) ? 4 : (rt == 3'd2) ? 16 : 0;
        store = (rt == 3'd1 || rt == 3'd2 || rt == 3'd3 || rt == 3'd6) && (len >= need);
        if (len < need) return 16'h0080;
        r  = (idx == 6'd12) ? 16'h0005 : 16'h0001;
        cs = {b[7:0], b[15:8], b[23:16], b[31:24]};
        if (rt == 3'd1 && (cs & 32'hFDF9_0000) != 0) r[14] = 1'b1;
        if (rt == 3'd6 && ({16'd0, cs[15:0]} & 32'h0000_E008) != 0) r[14] = 1'b1;
        return r;
    endfunction

    task automatic respond(int len, logic [127:0] b, logic [15:0] clr);
        logic st;
        logic [15:0] s;
        if (m_busy) begin
            s = exp_set(m_rt, m_idx, len, b, st);
            m_status = (m_status & ~clr) | s;
            if (st) for (int i = 0; i < 8; i++)
                m_rsp[i] = {b[8*(2*(7-i)) +: 8], b[8*(2*(7-i)+1) +: 8]};
            m_busy = 0;
        end else begin
            m_status = m_status & ~clr;
        end
        card_done_i = 1'b1; card_len_i = 5'(len); card_bytes_i = b;
        if (clr != 0) begin wr_en = 1'b1; wr_addr = 3'd4; wr_data = clr; end
        tick();
        card_done_i = 1'b0; wr_en = 1'b0;
    endtask

    function automatic logic [127:0] pat(logic [7:0] seed, logic [31:0] head);
        logic [127:0] b;
        for (int j = 0; j < 16; j++) b[8*j +: 8] = seed + 8'(j * 13);
        b[31:0] = {head[7:0], head[15:8], head[23:16], head[31:24]};
        return b;
    endfunction

    // monitor: compare queued expectations half a cycle later
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                item_t e;
                e = exp_q.pop_front();
                checks++;
                if (status_o !== e.st || irq_o !== e.irq || busy_o !== e.bsy ||
                    card_req_o !== e.req || card_wait_o !== e.wt || card_arg_o !== e.arg ||
                    (e.req && card_index_o !== e.idx) || rsp_word_o !== e.word) begin
                    errors++;
                    $display("FAIL %s: act st=%h irq=%b busy=%b req=%b wait=%b arg=%h idx=%0d w[%0d]=%h exp st=%h irq=%b busy=%b req=%b wait=%b arg=%h idx=%0d w=%h",
                             e.tag, status_o, irq_o, busy_o, card_req_o, card_wait_o, card_arg_o,
                             card_index_o, e.sel, rsp_word_o, e.st, e.irq, e.bsy, e.req, e.wt,
                             e.arg, e.idx, e.word);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic run_cmd(string tag, logic [15:0] w, int len, logic [127:0] b);
        issue(w);
        snap({tag, " request"}, 3'd0);
        m_req = 0;
        respond(len, b, 16'h0);
        snap_all(tag);
        wr(3'd4, 16'hFFFF);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_rsp[i] = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        snap_all("R1 reset");

        wr(3'd1, 16'h1234); snap("R2 arg low", 0);
        wr(3'd2, 16'hABCD); snap("R2 arg high keeps low", 0);
        wr(3'd1, 16'h5678); snap("R2 arg low keeps high", 0);

        issue(16'h0111); snap("R3 disabled command ignored", 0);

        wr(3'd3, 16'h0001);
        wr(3'd5, 16'hFFFF);

        // R4 R9 R8 R11: type 1 clean status, kind/dir fields
        run_cmd("R8 R9 type1 clean", 16'hB111, 6, pat(8'h21, 32'h0000_0900));
        snap("R10 status cleared", 0);
        // R7 error bits, with and without busy flag
        run_cmd("R7 type1 out-of-range", 16'h0111, 4, pat(8'h30, 32'h8000_0000));
        run_cmd("R7 type1 busy illegal", 16'h0911, 4, pat(8'h40, 32'h0040_0000));
        run_cmd("R7 type1 bit outside mask", 16'h0111, 4, pat(8'h44, 32'h0206_FFFF));
        // R6 long length boundary
        run_cmd("R6 R8 type2 full", 16'h0202, 16, pat(8'h55, 32'hFFFF_FFFF));
        run_cmd("R6 type2 short", 16'h0202, 15, pat(8'h66, 32'h1234_5678));
        run_cmd("R6 type3 short", 16'h0329, 3, pat(8'h70, 32'hFFFF_FFFF));
        run_cmd("R7 type3 no error", 16'h0329, 4, pat(8'h71, 32'hFFFF_FFFF));
        run_cmd("R7 type6 bit13", 16'h0603, 4, pat(8'h80, 32'h0000_2000));
        run_cmd("R7 type6 bit3", 16'h0603, 4, pat(8'h81, 32'h0000_0008));
        run_cmd("R7 type6 clean", 16'h0603, 4, pat(8'h82, 32'hFFFF_1FF7));
        run_cmd("R9 stop index", 16'h010C, 4, pat(8'h90, 32'h0));
        run_cmd("R6 R8 type0 none", 16'h0005, 0, pat(8'h91, 32'h0));
        run_cmd("R6 type5 none", 16'h0505, 0, pat(8'h92, 32'h0));

        // R5: init pseudo-command clears words after a stored reply
        run_cmd("R5 prep", 16'h0202, 16, pat(8'hA0, 32'h0));
        issue(16'h0080);
        snap_all("R5 init pseudo");
        wr(3'd4, 16'hFFFF);
        run_cmd("R5 init flag nonzero index", 16'h0185, 4, pat(8'hA5, 32'h0));

        // R3 busy: second write ignored; R12 done while idle
        issue(16'h0107);
        snap("R4 request", 0);
        m_req = 0;
        issue(16'h0108);
        snap("R3 ignored while pending", 0);
        respond(4, pat(8'hB0, 32'h0), 16'h0);
        snap("R3 reply after ignore", 0);
        respond(4, pat(8'hB1, 32'h8000_0000), 16'h0);
        snap_all("R12 idle done ignored");

        // R10 set wins over simultaneous clear
        wr(3'd4, 16'hFFFF);
        issue(16'h0113);
        m_req = 0;
        tick();
        respond(4, pat(8'hC0, 32'h8000_0000), 16'h4001);
        snap("R10 set beats clear", 0);
        wr(3'd4, 16'h0001);
        snap("R10 partial clear", 0);

        // R11 mask selection
        wr(3'd5, 16'h0080);
        snap("R11 masked off", 0);
        wr(3'd5, 16'hC000);
        snap("R11 bit14 enabled", 0);
        wr(3'd5, 16'h0000);
        snap("R11 mask zero", 0);

        repeat (2) tick();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule